// File: doc/BRIEF.md
# Serial NOR Flash Slave Model

This block is a synthesizable stand-in for a small serial NOR flash memory. It sits on the far side of a four-wire SPI link (mode 0: the slave samples the data-in line on the rising serial clock, shifts its output on the falling serial clock, most significant bit first). A flash command engine under test can drive it exactly as it would drive a real part. The serial clock and select lines are oversampled by the system clock, so the model lives in a single clock domain.

The model decodes single-byte opcodes and keeps a status byte. It supports streaming reads, programming within a 256-byte page, erase of one sector or of the whole array, a write-status command and a signature read that reports the device size. Program and erase run for a busy time set by a parameter. During that time the write-in-progress flag is raised, and only status reads are honoured. The storage is an on-chip byte array. At reset it comes up fully erased.

Top module: `spi_nor_model`

## Requirements
- R1: After reset the status byte reads 0x00 and every array byte reads 0xFF.
- R2: Opcode 0xAB followed by three dummy bytes returns the size code 0x13 + SIZE_CODE (0x13, 0x14, 0x15, 0x16, 0x17 for 1, 2, 4, 8, 16 MiB).
- R3: Opcode 0x03 followed by a 24-bit address (most significant byte first) returns the byte at that address, then the following bytes in turn. The address is taken modulo the array size.
- R4: Opcode 0x05 returns the status byte for as long as the slave is selected. Bit 0 is write-in-progress, bit 1 is the write-enable latch, bits 4:2 are the protect field, bit 7 is the status-lock bit, and bits 6:5 read 0. Opcode 0x06 sets bit 1 and opcode 0x04 clears it.
- R5: Page program (0x02), sector erase (0xD8), bulk erase (0xC7) and write status (0x01) have no effect unless the write-enable latch is set when they are committed.
- R6: Page program (0x02, 24-bit address, one or more data bytes) ANDs each data byte into the array. Bytes that run past the end of a 256-byte page wrap to the start of that same page.
- R7: While write-in-progress is set, every opcode except 0x05 is ignored. An ignored read returns 0x00 bytes.
- R8: A committed program or erase raises write-in-progress for PROG_BUSY, SECTOR_BUSY or BULK_BUSY cycles, with a minimum of one cycle per byte touched. Write-in-progress and the write-enable latch then clear in the same cycle.
- R9: Sector erase sets to 0xFF the 2^SECTOR_BITS-byte aligned sector that holds the address and leaves other sectors unchanged. Bulk erase sets the whole array to 0xFF.
- R10: A command takes effect only when select rises after a whole number of bytes. A partial final byte aborts it. The data-out line is low while the slave is deselected.
- R11: Write status (0x01 plus a data byte) loads bits 7 and 4:2 from the last full data byte, clears the write-enable latch and does not raise write-in-progress.
- R12: Opcodes 0x0B, 0xB9 and any unlisted code have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial link |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low slave select |
| sck | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data into the slave |
| miso | output | 1 | Serial data out of the slave |

## Verification
Two functions can fall in the same system cycle: the erase/program walker finishing, which drops write-in-progress and the write-enable latch, and the serial side loading the next status byte for a status poll that is still running. The bench provokes this by holding select low through a whole program operation and clocking out status bytes back to back. Every observed byte must be 0x03 or 0x00, and once 0x00 appears, 0x03 must never return. A torn value such as 0x01 or 0x02 would show that the two flags were updated apart.

// File: rtl/spi_nor_pkg.sv
package spi_nor_pkg;
  localparam int PAGE_BITS = 8;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_SECT = 8'hD8;
  localparam logic [7:0] OP_BULK = 8'hC7;
  localparam logic [7:0] OP_SIG  = 8'hAB;

  typedef struct packed {
    logic                 setWel;
    logic                 clrWel;
    logic                 wrStatus;
    logic                 lockIn;
    logic [2:0]           protIn;
    logic                 bufClear;
    logic                 bufWrite;
    logic [PAGE_BITS-1:0] bufIdx;
    logic [7:0]           bufData;
    logic                 startProg;
    logic                 startSector;
    logic                 startBulk;
  } norStrobe_t;
endpackage

// File: rtl/spi_nor_ctrl.sv
module spi_nor_ctrl
  import spi_nor_pkg::*;
#(
  parameter int         MEM_BITS = 11,
  parameter logic [7:0] SIG_BYTE = 8'h13
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                sck,
  input  logic                mosi,
  input  logic [7:0]          statusByte,
  input  logic [7:0]          rdByte,
  output logic [MEM_BITS-1:0] rdAddr,
  output logic [MEM_BITS-1:0] opAddr,
  output logic                miso,
  output norStrobe_t          strb
);
  typedef enum logic [1:0] {PH_OPC, PH_ADDR, PH_DATA, PH_IGN} phase_t;

  logic                 sckQ, csQ, misoQ, gotData;
  logic [2:0]           bitCnt;
  logic [1:0]           addrCnt;
  logic [7:0]           shReg, op, lastData, txSh, nextTx;
  logic [MEM_BITS-1:0]  addrQ, rdAddrQ;
  logic [PAGE_BITS-1:0] pageIdx;
  phase_t               phase;

  logic sckRise, sckFall, csRise, byteDone, commit, wip, wel;
  logic [7:0] newByte;

  assign sckRise  = sck & ~sckQ & ~csN;
  assign sckFall  = ~sck & sckQ & ~csN;
  assign csRise   = csN & ~csQ;
  assign byteDone = sckRise && (bitCnt == 3'd7);
  assign newByte  = {shReg[6:0], mosi};
  assign commit   = csRise && (bitCnt == 3'd0) && (phase == PH_DATA);
  assign wip      = statusByte[0];
  assign wel      = statusByte[1];

  always_comb begin
    nextTx = 8'h00;
    if (phase == PH_DATA) begin
      if (op == OP_RDSR)      nextTx = statusByte;
      else if (op == OP_READ) nextTx = rdByte;
      else if (op == OP_SIG)  nextTx = SIG_BYTE;
    end
  end

  always_comb begin
    strb          = '0;
    strb.setWel   = commit && (op == OP_WREN);
    strb.clrWel   = commit && (op == OP_WRDI);
    strb.wrStatus = commit && (op == OP_WRSR) && gotData && wel;
    strb.lockIn   = lastData[7];
    strb.protIn   = lastData[4:2];
    strb.bufClear = byteDone && (phase == PH_OPC) && (newByte == OP_PROG) && !wip;
    strb.bufWrite = byteDone && (phase == PH_DATA) && (op == OP_PROG);
    strb.bufIdx   = pageIdx;
    strb.bufData  = newByte;
    strb.startProg   = commit && (op == OP_PROG) && gotData && wel;
    strb.startSector = commit && (op == OP_SECT) && wel;
    strb.startBulk   = commit && (op == OP_BULK) && wel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ <= 1'b0; csQ <= 1'b1; misoQ <= 1'b0; gotData <= 1'b0;
      bitCnt <= '0; addrCnt <= '0; shReg <= '0; op <= '0;
      lastData <= '0; txSh <= '0; addrQ <= '0; rdAddrQ <= '0;
      pageIdx <= '0; phase <= PH_OPC;
    end else begin
      sckQ <= sck;
      csQ  <= csN;
      if (csN) begin
        bitCnt <= '0; addrCnt <= '0; gotData <= 1'b0;
        misoQ <= 1'b0; phase <= PH_OPC;
      end else begin
        if (sckRise) begin
          bitCnt <= bitCnt + 3'd1;
          shReg  <= newByte;
          if (bitCnt == 3'd7) begin
            case (phase)
              PH_OPC: begin
                op <= newByte;
                if (wip && newByte != OP_RDSR) phase <= PH_IGN;
                else begin
                  case (newByte)
                    OP_READ, OP_PROG, OP_SECT, OP_SIG:          phase <= PH_ADDR;
                    OP_WREN, OP_WRDI, OP_RDSR, OP_WRSR, OP_BULK: phase <= PH_DATA;
                    default:                                     phase <= PH_IGN;
                  endcase
                end
              end
              PH_ADDR: begin
                addrQ   <= MEM_BITS'({addrQ, newByte});
                addrCnt <= addrCnt + 2'd1;
                if (addrCnt == 2'd2) begin
                  phase   <= PH_DATA;
                  rdAddrQ <= MEM_BITS'({addrQ, newByte});
                  pageIdx <= newByte;
                end
              end
              PH_DATA: begin
                gotData  <= 1'b1;
                lastData <= newByte;
                if (op == OP_PROG) pageIdx <= pageIdx + 1'b1;
              end
              default: ;
            endcase
          end
        end
        if (sckFall) begin
          if (bitCnt == 3'd0) begin
            misoQ <= nextTx[7];
            txSh  <= {nextTx[6:0], 1'b0};
            if (phase == PH_DATA && op == OP_READ) rdAddrQ <= rdAddrQ + 1'b1;
          end else begin
            misoQ <= txSh[7];
            txSh  <= {txSh[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign miso   = misoQ;
  assign rdAddr = rdAddrQ;
  assign opAddr = addrQ;
endmodule

// File: rtl/spi_nor_data.sv
module spi_nor_data
  import spi_nor_pkg::*;
#(
  parameter int MEM_BITS    = 11,
  parameter int SECTOR_BITS = 9,
  parameter int PROG_BUSY   = 1000,
  parameter int SECTOR_BUSY = 1500,
  parameter int BULK_BUSY   = 3000
) (
  input  logic                clk,
  input  logic                rstN,
  input  norStrobe_t          strb,
  input  logic [MEM_BITS-1:0] opAddr,
  input  logic [MEM_BITS-1:0] rdAddr,
  output logic [7:0]          rdByte,
  output logic [7:0]          statusByte
);
  localparam int MEM_BYTES  = 1 << MEM_BITS;
  localparam int PAGE_BYTES = 1 << PAGE_BITS;
  localparam int SEC_BYTES  = 1 << SECTOR_BITS;
  localparam int PROG_T = (PROG_BUSY > PAGE_BYTES) ? PROG_BUSY : PAGE_BYTES;
  localparam int SEC_T  = (SECTOR_BUSY > SEC_BYTES) ? SECTOR_BUSY : SEC_BYTES;
  localparam int BULK_T = (BULK_BUSY > MEM_BYTES) ? BULK_BUSY : MEM_BYTES;
  localparam int MAX_T  = (PROG_T > SEC_T) ? ((PROG_T > BULK_T) ? PROG_T : BULK_T)
                                           : ((SEC_T > BULK_T) ? SEC_T : BULK_T);
  localparam int CNT_W  = $clog2(MAX_T + 1);

  typedef enum logic [1:0] {K_PROG, K_SECT, K_BULK} kind_t;

  logic [7:0]          mem  [MEM_BYTES];
  logic [7:0]          pbuf [PAGE_BYTES];
  logic                busy, wel, lock;
  logic [2:0]          prot;
  kind_t               kind;
  logic [CNT_W-1:0]    cnt, limit, span;
  logic [MEM_BITS-1:0] base, wAddr;

  always_comb begin
    case (kind)
      K_PROG:  begin limit = CNT_W'(PROG_T); span = CNT_W'(PAGE_BYTES); end
      K_SECT:  begin limit = CNT_W'(SEC_T);  span = CNT_W'(SEC_BYTES);  end
      default: begin limit = CNT_W'(BULK_T); span = CNT_W'(MEM_BYTES);  end
    endcase
  end

  assign wAddr = base + MEM_BITS'(cnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++)  mem[i]  <= 8'hFF;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'hFF;
      busy <= 1'b0; wel <= 1'b0; lock <= 1'b0; prot <= '0;
      kind <= K_PROG; cnt <= '0; base <= '0;
    end else begin
      if (strb.bufClear) begin
        for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'hFF;
      end else if (strb.bufWrite) begin
        pbuf[strb.bufIdx] <= pbuf[strb.bufIdx] & strb.bufData;
      end
      if (strb.setWel) wel <= 1'b1;
      if (strb.clrWel) wel <= 1'b0;
      if (strb.wrStatus) begin
        lock <= strb.lockIn;
        prot <= strb.protIn;
        wel  <= 1'b0;
      end
      if (strb.startProg || strb.startSector || strb.startBulk) begin
        busy <= 1'b1;
        cnt  <= '0;
        if (strb.startProg) begin
          kind <= K_PROG;
          base <= {opAddr[MEM_BITS-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
        end else if (strb.startSector) begin
          kind <= K_SECT;
          base <= {opAddr[MEM_BITS-1:SECTOR_BITS], {SECTOR_BITS{1'b0}}};
        end else begin
          kind <= K_BULK;
          base <= '0;
        end
      end else if (busy) begin
        if (cnt < span)
          mem[wAddr] <= (kind == K_PROG) ? (mem[wAddr] & pbuf[cnt[PAGE_BITS-1:0]]) : 8'hFF;
        cnt <= cnt + 1'b1;
        if (cnt == limit - 1'b1) begin
          busy <= 1'b0;
          wel  <= 1'b0;
        end
      end
    end
  end

  assign rdByte     = mem[rdAddr];
  assign statusByte = {lock, 2'b00, prot, wel, busy};
endmodule

// File: rtl/spi_nor_model.sv
module spi_nor_model
  import spi_nor_pkg::*;
#(
  parameter int MEM_BITS    = 11,
  parameter int SECTOR_BITS = 9,
  parameter int SIZE_CODE   = 0,
  parameter int PROG_BUSY   = 1000,
  parameter int SECTOR_BUSY = 1500,
  parameter int BULK_BUSY   = 3000
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  localparam logic [7:0] SIG_BYTE = 8'(8'h13 + SIZE_CODE);

  norStrobe_t          strb;
  logic [MEM_BITS-1:0] rdAddr, opAddr;
  logic [7:0]          rdByte, statusByte;
  logic                wip, wel, startAny;

  spi_nor_ctrl #(.MEM_BITS(MEM_BITS), .SIG_BYTE(SIG_BYTE)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi),
    .statusByte(statusByte), .rdByte(rdByte), .rdAddr(rdAddr),
    .opAddr(opAddr), .miso(miso), .strb(strb)
  );

  spi_nor_data #(
    .MEM_BITS(MEM_BITS), .SECTOR_BITS(SECTOR_BITS), .PROG_BUSY(PROG_BUSY),
    .SECTOR_BUSY(SECTOR_BUSY), .BULK_BUSY(BULK_BUSY)
  ) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .opAddr(opAddr), .rdAddr(rdAddr),
    .rdByte(rdByte), .statusByte(statusByte)
  );

  assign wip      = statusByte[0];
  assign wel      = statusByte[1];
  assign startAny = strb.startProg | strb.startSector | strb.startBulk;
endmodule

// File: rtl/spi_nor_model_chk.sv
module spi_nor_model_chk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic miso,
  input logic wip,
  input logic wel,
  input logic startAny
);
  // R7: no new program or erase may begin while one is running
  a_r7_busy_blocks_start: assert property (@(posedge clk) disable iff (!rstN)
    wip |-> !startAny);
  // R5: an operation only starts with the enable latch set
  a_r5_start_needs_wel: assert property (@(posedge clk) disable iff (!rstN)
    startAny |-> wel);
  // R8: the latch is gone by the time busy drops
  a_r8_wel_drops_with_wip: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> !wel);
  // R8: busy rises only after a start strobe
  a_r8_wip_from_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> $past(startAny));
  // R10: data-out stays low while deselected
  a_r10_miso_quiet: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !miso);
endmodule

bind spi_nor_model spi_nor_model_chk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .miso(miso),
  .wip(wip), .wel(wel), .startAny(startAny)
);

// File: tb/tb_spi_nor_model.sv
module tb_spi_nor_model;
  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso;
  int checks = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  spi_nor_model dut (.clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi), .miso(miso));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks + 1);
      $finish;
    end
  end

  // addr[26:16], program data[15:8], expected readback[7:0]
  localparam logic [26:0] VEC [6] = '{
    {11'h010, 8'hA5, 8'hA5}, {11'h010, 8'h0F, 8'h05}, {11'h011, 8'h00, 8'h00},
    {11'h3FF, 8'h5A, 8'h5A}, {11'h200, 8'hC3, 8'hC3}, {11'h7FF, 8'h81, 8'h81}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic sel();
    @(negedge clk) csN = 1'b0;
    half();
  endtask

  task automatic desel();
    half();
    csN = 1'b1;
    mosi = 1'b0;
    half();
  endtask

  task automatic xferBits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      half();
      rx[i] = miso;
      sck = 1'b1;
      half();
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xferBits(tx, 8, rx);
  endtask

  task automatic put(input logic [7:0] tx);
    logic [7:0] d;
    xfer(tx, d);
  endtask

  task automatic simple(input logic [7:0] opc);
    sel(); put(opc); desel();
  endtask

  task automatic readStatus(output logic [7:0] st);
    sel(); put(8'h05); xfer(8'h00, st); desel();
  endtask

  task automatic waitIdle();
    logic [7:0] st;
    for (int i = 0; i < 40; i++) begin
      readStatus(st);
      if (st[0] == 1'b0) break;
    end
  endtask

  task automatic readByte(input logic [10:0] a, output logic [7:0] d);
    sel(); put(8'h03); put(8'h00); put({5'd0, a[10:8]}); put(a[7:0]);
    xfer(8'h00, d); desel();
  endtask

  task automatic progOne(input logic [10:0] a, input logic [7:0] d);
    sel(); put(8'h02); put(8'h00); put({5'd0, a[10:8]}); put(a[7:0]); put(d); desel();
  endtask

  initial begin
    logic [7:0] st, d, prev;
    logic seenIdle, torn;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    readStatus(st);      check("R1 status", st, 8'h00);
    readByte(11'h5A5, d); check("R1 erased", d, 8'hFF);

    // R2: signature
    sel(); put(8'hAB); put(8'h00); put(8'h00); put(8'h00); xfer(8'h00, d); desel();
    check("R2 signature", d, 8'h13);

    // R4: latch set and clear
    simple(8'h06); readStatus(st); check("R4 wren", st, 8'h02);
    simple(8'h04); readStatus(st); check("R4 wrdi", st, 8'h00);

    // R6 R3: vector table of single-byte programs
    for (int k = 0; k < 6; k++) begin
      simple(8'h06);
      progOne(VEC[k][26:16], VEC[k][15:8]);
      waitIdle();
      readByte(VEC[k][26:16], d);
      check("R6 table", d, VEC[k][7:0]);
    end

    // R3: streaming read crosses into next byte
    sel(); put(8'h03); put(8'h00); put(8'h00); put(8'h10); xfer(8'h00, d);
    check("R3 stream0", d, 8'h05); xfer(8'h00, d); check("R3 stream1", d, 8'h00); desel();
    // R10: miso low after deselect
    @(negedge clk); check("R10 miso idle", {7'd0, miso}, 8'h00);

    // R5: program without latch ignored
    progOne(11'h020, 8'h00); readStatus(st); check("R5 no wel busy", st, 8'h00);
    readByte(11'h020, d); check("R5 no wel prog", d, 8'hFF);

    // R6: page wrap, R8 busy flags, R7 ignored read
    simple(8'h06);
    sel(); put(8'h02); put(8'h00); put(8'h01); put(8'hFE);
    put(8'h11); put(8'h22); put(8'h33); put(8'h44); desel();
    readStatus(st); check("R8 busy status", st, 8'h03);
    readByte(11'h1FE, d); check("R7 read ignored", d, 8'h00);
    waitIdle();
    readStatus(st); check("R8 idle status", st, 8'h00);
    readByte(11'h1FE, d); check("R6 wrap a", d, 8'h11);
    readByte(11'h1FF, d); check("R6 wrap b", d, 8'h22);
    readByte(11'h100, d); check("R6 wrap c", d, 8'h33);
    readByte(11'h101, d); check("R6 wrap d", d, 8'h44);
    readByte(11'h200, d); check("R6 next page kept", d, 8'hC3);

    // R10: partial byte aborts
    sel(); put(8'h06); xferBits(8'hFF, 3, d); desel();
    readStatus(st); check("R10 partial wren", st, 8'h00);
    simple(8'h06);
    sel(); put(8'h02); put(8'h00); put(8'h00); put(8'h30); put(8'h00); xferBits(8'h00, 3, d); desel();
    readStatus(st); check("R10 partial prog", st, 8'h02);
    readByte(11'h030, d); check("R10 partial data", d, 8'hFF);

    // R12: unsupported opcodes
    simple(8'hB9); simple(8'h0B); simple(8'h77);
    readStatus(st); check("R12 no effect", st, 8'h02);
    readByte(11'h010, d); check("R12 array", d, 8'h05);

    // R11: write status
    sel(); put(8'h01); put(8'hFF); desel();
    readStatus(st); check("R11 wrsr", st, 8'h9C);
    sel(); put(8'h01); put(8'h00); desel();
    readStatus(st); check("R5 wrsr no wel", st, 8'h9C);
    simple(8'h06); sel(); put(8'h01); put(8'h00); desel();
    readStatus(st); check("R11 wrsr clear", st, 8'h00);

    // R9: sector erase
    simple(8'h06);
    sel(); put(8'hD8); put(8'h00); put(8'h02); put(8'hAB); desel();
    waitIdle();
    readByte(11'h200, d); check("R9 sector lo", d, 8'hFF);
    readByte(11'h3FF, d); check("R9 sector hi", d, 8'hFF);
    readByte(11'h1FE, d); check("R9 below kept", d, 8'h11);
    readByte(11'h7FF, d); check("R9 above kept", d, 8'h81);

    // R8 R4: continuous status poll across completion
    simple(8'h06); progOne(11'h040, 8'h00);
    sel(); put(8'h05);
    seenIdle = 1'b0; torn = 1'b0; prev = 8'h03;
    for (int i = 0; i < 40; i++) begin
      xfer(8'h00, st);
      if (!(st == 8'h03 || st == 8'h00)) torn = 1'b1;
      if (seenIdle && st != 8'h00) torn = 1'b1;
      if (st == 8'h00) seenIdle = 1'b1;
      if (st != 8'h00) prev = st;
    end
    desel();
    check("R8 poll no tear", {7'd0, torn}, 8'h00);
    check("R8 poll finished", {7'd0, seenIdle}, 8'h01);
    check("R4 poll busy value", prev, 8'h03);

    // R9: bulk erase
    simple(8'h06); simple(8'hC7); waitIdle();
    readByte(11'h010, d); check("R9 bulk a", d, 8'hFF);
    readByte(11'h7FF, d); check("R9 bulk b", d, 8'hFF);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule